// File: doc/BRIEF.md
# Self-Timed Write Cycle Controller

This block runs the internal programming phase of a serial non-volatile word memory once a write command has been completely shifted in by the command front end. A single start strobe hands it the target address and the data word. The controller captures both and waits a short settle delay. It then pulls its ready line low for a fixed programming interval, counted in system clocks. At the end of that interval it issues exactly one storage write, and ready goes high again without outside help.

While it is programming, the controller refuses new commands. A write-control input can cancel the operation. A cancel that arrives during the settle delay leaves storage untouched. A cancel that arrives during programming stops the cycle at once and writes a defined all-ones corruption value to the target word. After an accepted write, the host can watch progress on the serial data line: it drops chip select while the serial clock is low, and the ready level is then mirrored until chip select rises. Once ready has returned, raising chip select sends the interface back to idle and pulses a reset towards the command front end.

Top module: `eep_prog_ctrl`

## Requirements
- R1: During and right after synchronous reset, ready is 1, and the storage write strobe, the status-on-DO enable and the interface reset pulse are all 0.
- R2: A start strobe seen in idle with write control low is accepted. Ready falls at the edge exactly HOLD_CYC clocks after the accepting edge and then stays low for exactly PROG_CYC clocks.
- R3: On normal completion, ready returns high at the edge HOLD_CYC+PROG_CYC after acceptance. At that same edge the storage write strobe rises for exactly one clock, carrying the captured address and data.
- R4: Write control high together with the start strobe, or at any edge of the settle delay, cancels the write. Ready never falls, no storage write occurs, and the controller returns to idle.
- R5: Write control high at any edge of the programming interval ends it at that edge. Ready rises, and a one-clock storage write of all-ones data to the captured address is issued.
- R6: Start strobes that arrive while the controller is busy or awaiting chip select are ignored. The pending write keeps its address, data and timing, and no new cycle begins.
- R7: After an accepted write, a 1-to-0 change of chip select (chip select high = deselected) sampled while the serial clock is 0 sets the status enable at the next edge. The enable then holds until chip select is sampled high, and while it is set the DO status bit equals ready. A fall sampled with the serial clock at 1 does not set it.
- R8: After a cycle has ended, chip select sampled high returns the controller to idle and gives a one-clock interface reset pulse. Until that happens, start strobes are ignored.
- R9: The level of chip select has no effect on a cycle in progress. A write that runs with chip select held high still completes on time and commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_start | input | 1 | One-clock strobe: a write command has been fully received |
| wr_addr | input | AW | Target word address, captured on acceptance |
| wr_data | input | DW | Data word, captured on acceptance |
| csel | input | 1 | Chip select level, 1 = deselected |
| sck | input | 1 | Current level of the serial clock |
| wctl | input | 1 | Write control, 1 = inhibit or abort |
| rdy | output | 1 | Ready (1) / busy (0) |
| do_stat_en | output | 1 | Serial output should carry the status bit |
| do_stat | output | 1 | Status bit for the serial output, equal to rdy while enabled |
| iface_rst | output | 1 | One-clock pulse that returns the command front end to idle |
| mem_we | output | 1 | Storage write strobe |
| mem_addr | output | AW | Storage write address |
| mem_wdata | output | DW | Storage write data |

## Verification
The bench aims at the edges of both cancel windows: write control on the very first and the very last edge of the settle delay, and on the first and last edge of programming. A design with the priority backwards would either commit the real word when it should cancel, or let a late cancel slip into a clean write rather than the all-ones corruption. Rejected start strobes arrive with different address and data, both during programming and in the wait for chip select. A controller that let them in would write the wrong word or drop ready a second time. The status mirror is driven with a chip-select fall while the serial clock is high and with chip select high through a whole cycle, which catches an enable that ignores the clock level or a programming run that chip select can stop.

// File: rtl/eep_prog_pkg.sv
// Package: shared phase encoding for the self-timed write cycle controller.
// Assumes: nothing; holds only the type definitions.
package eep_prog_pkg;

    // Controller phases: idle, settle delay, programming, wait for chip select.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_BURN = 2'd2,
        PH_PARK = 2'd3
    } phase_t;

endpackage

// File: rtl/eep_prog_timer.sv
// Module: eep_prog_timer
// Counts enabled clocks and flags the clock on which the count reaches lim-1.
// Assumes: lim >= 1, and clr is pulsed on every phase change so each
// interval starts from zero. The count freezes while en is low.
module eep_prog_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] lim,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Interval counter: cleared on a phase change, otherwise advances while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Last-clock flag for the running interval.
    always_comb begin
        expired = en && (cnt_q == (lim - CW'(1)));
    end

    AST_TMR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (cnt_q < lim)) else $error("timer ran past its limit"); // R2

endmodule

// File: rtl/eep_prog_status.sv
// Module: eep_prog_status
// Mirrors ready on the serial data output once a write has been accepted.
// Assumes: csel = 1 means deselected; sck is the present serial clock level.
// arm_set marks an accepted write, and arm_clr marks the return to idle.
module eep_prog_status (
    input  logic clk,
    input  logic rst_n,
    input  logic csel,
    input  logic sck,
    input  logic arm_set,
    input  logic arm_clr,
    input  logic rdy,
    output logic do_stat_en,
    output logic do_stat
);

    logic cs_q;
    logic armed_q;
    logic en_q;
    logic cs_fall;

    // Edge of interest: chip select going active while the serial clock is low.
    always_comb begin
        cs_fall = cs_q && !csel && !sck;
    end

    // Remember the previous chip select level so a fall can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
        end else begin
            cs_q <= csel;
        end
    end

    // Arm flag: a write has been accepted and the interface is not yet back in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (arm_set) begin
            armed_q <= 1'b1;
        end else if (arm_clr) begin
            armed_q <= 1'b0;
        end
    end

    // Status enable: set by a qualified fall, dropped as soon as chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (csel) begin
            en_q <= 1'b0;
        end else if (cs_fall && armed_q) begin
            en_q <= 1'b1;
        end
    end

    // Output drive: the status bit follows ready only while enabled.
    always_comb begin
        do_stat_en = en_q;
        do_stat    = en_q ? rdy : 1'b0;
    end

    AST_STAT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        do_stat_en |-> !$past(csel)) else $error("status shown while deselected"); // R7
    AST_STAT_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_stat_en) |-> !$past(sck)) else $error("status enabled on a high clock"); // R7

endmodule

// File: rtl/eep_prog_commit.sv
// Module: eep_prog_commit
// Captures the write target when a command is accepted and drives the storage
// write port for one clock when programming ends, normally or by abort.
// Assumes: cap and fire never coincide, and fire is a single-clock request.
module eep_prog_commit #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    input  logic          fire,
    input  logic          corrupt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          we_q;
    logic [AW-1:0] waddr_q;
    logic [DW-1:0] wdata_q;

    // Target capture on acceptance; held for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (cap) begin
            addr_q <= cap_addr;
            data_q <= cap_data;
        end
    end

    // Storage port: a single-clock strobe with the real word or the corruption value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= fire;
            if (fire) begin
                waddr_q <= addr_q;
                wdata_q <= corrupt ? {DW{1'b1}} : data_q;
            end
        end
    end

    // Port assignment.
    always_comb begin
        mem_we    = we_q;
        mem_addr  = waddr_q;
        mem_wdata = wdata_q;
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we) else $error("storage strobe longer than one clock"); // R3

endmodule

// File: rtl/eep_prog_ctrl.sv
// Module: eep_prog_ctrl (top)
// Self-timed write cycle controller: accepts a captured write, waits a settle
// delay, holds busy for the programming interval, commits once, supports
// cancel/abort through write control and mirrors status on the serial output.
// Assumes: wr_start is a single-clock strobe from the command front end;
// csel = 1 means deselected; wctl = 1 means inhibit. HOLD_CYC, PROG_CYC >= 1.
module eep_prog_ctrl #(
    parameter int AW       = 10,
    parameter int DW       = 16,
    parameter int HOLD_CYC = 4,
    parameter int PROG_CYC = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          csel,
    input  logic          sck,
    input  logic          wctl,
    output logic          rdy,
    output logic          do_stat_en,
    output logic          do_stat,
    output logic          iface_rst,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    import eep_prog_pkg::*;

    localparam int LIM_MAX = (HOLD_CYC > PROG_CYC) ? HOLD_CYC : PROG_CYC;
    localparam int CW      = $clog2(LIM_MAX + 1);

    phase_t        ph_q;
    phase_t        ph_d;
    logic          accept;
    logic          cancel;
    logic          fire;
    logic          corrupt;
    logic          go_idle;
    logic          tmr_exp;
    logic          tmr_clr;
    logic          tmr_en;
    logic [CW-1:0] tmr_lim;
    logic          irst_q;

    // Phase decision: acceptance, cancel/abort priority over expiry, return to idle.
    always_comb begin
        ph_d    = ph_q;
        accept  = 1'b0;
        cancel  = 1'b0;
        fire    = 1'b0;
        corrupt = 1'b0;
        go_idle = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (wr_start && !wctl) begin
                    ph_d   = PH_HOLD;
                    accept = 1'b1;
                end
            end
            PH_HOLD: begin
                if (wctl) begin
                    ph_d   = PH_IDLE;
                    cancel = 1'b1;
                end else if (tmr_exp) begin
                    ph_d = PH_BURN;
                end
            end
            PH_BURN: begin
                if (wctl) begin
                    ph_d    = PH_PARK;
                    fire    = 1'b1;
                    corrupt = 1'b1;
                end else if (tmr_exp) begin
                    ph_d = PH_PARK;
                    fire = 1'b1;
                end
            end
            PH_PARK: begin
                if (csel) begin
                    ph_d    = PH_IDLE;
                    go_idle = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Interface reset pulse towards the command front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irst_q <= 1'b0;
        end else begin
            irst_q <= go_idle;
        end
    end

    // Timer control: runs only in the two timed phases and restarts on each change.
    always_comb begin
        tmr_en  = (ph_q == PH_HOLD) || (ph_q == PH_BURN);
        tmr_clr = (ph_d != ph_q);
        tmr_lim = (ph_q == PH_HOLD) ? CW'(HOLD_CYC) : CW'(PROG_CYC);
    end

    // Ready and pulse outputs.
    always_comb begin
        rdy       = (ph_q != PH_BURN);
        iface_rst = irst_q;
    end

    eep_prog_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .lim     (tmr_lim),
        .expired (tmr_exp)
    );

    eep_prog_commit #(.AW(AW), .DW(DW)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (accept),
        .cap_addr  (wr_addr),
        .cap_data  (wr_data),
        .fire      (fire),
        .corrupt   (corrupt),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    eep_prog_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .csel       (csel),
        .sck        (sck),
        .arm_set    (accept),
        .arm_clr    (cancel || go_idle),
        .rdy        (rdy),
        .do_stat_en (do_stat_en),
        .do_stat    (do_stat)
    );

    AST_BUSY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(ph_q) == PH_HOLD)) else $error("busy without settle delay"); // R2
    AST_CANCEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD && wctl) |=> (!mem_we && rdy)) else $error("cancelled write reached storage"); // R4
    AST_ABORT_CORRUPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BURN && wctl) |=> (mem_we && rdy && mem_wdata == {DW{1'b1}})) else $error("abort did not corrupt"); // R5
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BURN && wr_start && !wctl && !tmr_exp) |=> !rdy) else $error("start disturbed busy phase"); // R6
    AST_RST_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        iface_rst |-> (rdy && !mem_we)) else $error("interface reset while busy"); // R8

endmodule

// File: tb/tb_eep_prog_ctrl.sv
module tb_eep_prog_ctrl;

    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int HOLD  = 4;
    localparam int PROG  = 200;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_start;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          csel;
    logic          sck;
    logic          wctl;
    logic          rdy;
    logic          do_stat_en;
    logic          do_stat;
    logic          iface_rst;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    eep_prog_ctrl #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD), .PROG_CYC(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_data(wr_data), .csel(csel), .sck(sck), .wctl(wctl), .rdy(rdy),
        .do_stat_en(do_stat_en), .do_stat(do_stat), .iface_rst(iface_rst),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Expected stored word: mode 2 is an abort during programming.
    function automatic logic [DW-1:0] exp_word(input int mode, input logic [DW-1:0] d);
        return (mode == 2) ? {DW{1'b1}} : d;
    endfunction

    // Edge count of the final edge of a cycle, counted from the accepting edge.
    function automatic int end_edge(input int mode, input int k);
        if (mode == 1) return k + 1;
        if (mode == 2) return HOLD + 1 + k;
        return HOLD + PROG;
    endfunction

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One write cycle. mode 0 normal, 1 cancel in settle delay at edge k+1,
    // 2 abort in programming k edges after it began. noise adds csel/sck toggles
    // and rejected start strobes while busy.
    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int mode, input int k, input bit noise);
        int endt;
        endt     = end_edge(mode, k);
        wr_addr  = a;
        wr_data  = d;
        wctl     = 1'b0;
        wr_start = 1'b1;
        step();
        wr_start = 1'b0;
        for (int t = 1; t <= endt; t++) begin
            wctl = (mode != 0) && (t == endt);
            if (noise) begin
                csel = (t < endt - 1) ? 1'($urandom_range(0, 1)) : 1'b0;
                sck  = 1'($urandom_range(0, 1));
                if (t > HOLD && $urandom_range(0, 3) == 0) begin
                    wr_start = 1'b1;
                    wr_addr  = ~a;
                    wr_data  = ~d;
                end
            end
            step();
            wr_start = 1'b0;
            wr_addr  = a;
            wr_data  = d;
            if (mode == 1)
                chk("R4", "rdy in cancelled cycle", 32'(rdy), 32'd1);
            else
                chk("R2", "rdy timing", 32'(rdy), 32'((t < HOLD) || (t >= endt)));
            if (t < endt || mode == 1) begin
                chk("R6", "no early storage write", 32'(mem_we), 32'd0);
            end else begin
                chk(mode == 2 ? "R5" : "R3", "storage strobe", 32'(mem_we), 32'd1);
                chk(mode == 2 ? "R5" : "R3", "storage address", 32'(mem_addr), 32'(a));
                chk(mode == 2 ? "R5" : "R3", "storage data", 32'(mem_wdata), 32'(exp_word(mode, d)));
            end
        end
        wctl = 1'b0;
        csel = 1'b0;
        if (mode == 1) begin
            for (int j = 0; j < 2; j++) begin
                step();
                chk("R4", "no write after cancel", 32'(mem_we), 32'd0);
            end
        end else begin
            step();
            chk("R3", "strobe single clock", 32'(mem_we), 32'd0);
            // stray start while awaiting chip select must be ignored
            wr_start = 1'b1;
            step();
            wr_start = 1'b0;
            for (int j = 0; j <= HOLD + 1; j++) begin
                step();
                chk("R8", "start ignored before cs", 32'(rdy), 32'd1);
            end
            csel = 1'b1;
            step();
            chk("R8", "iface_rst pulse", 32'(iface_rst), 32'd1);
            step();
            chk("R8", "iface_rst single", 32'(iface_rst), 32'd0);
            csel = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; wr_start = 1'b0; wr_addr = '0; wr_data = '0;
        csel = 1'b1; sck = 1'b0; wctl = 1'b0;
        step(); step();
        chk("R1", "rdy in reset", 32'(rdy), 32'd1);
        rst_n = 1'b1;
        step();
        chk("R1", "rdy", 32'(rdy), 32'd1);
        chk("R1", "mem_we", 32'(mem_we), 32'd0);
        chk("R1", "do_stat_en", 32'(do_stat_en), 32'd0);
        chk("R1", "iface_rst", 32'(iface_rst), 32'd0);
        csel = 1'b0;
        step();

        // directed: plain write, cancel window edges, abort window edges
        run_op(10'h155, 16'hA5C3, 0, 0, 1'b0);
        run_op(10'h001, 16'h1234, 1, 0, 1'b0);
        run_op(10'h002, 16'h5678, 1, HOLD - 1, 1'b0);
        run_op(10'h3FF, 16'h0F0F, 2, 0, 1'b0);
        run_op(10'h200, 16'h0000, 2, PROG - 1, 1'b0);

        // R4: write control high with the start strobe
        wctl = 1'b1; wr_start = 1'b1; wr_addr = 10'h077;
        step();
        wr_start = 1'b0; wctl = 1'b0;
        for (int j = 0; j <= HOLD + 1; j++) begin
            step();
            chk("R4", "inhibited start keeps ready", 32'(rdy), 32'd1);
            chk("R4", "inhibited start no write", 32'(mem_we), 32'd0);
        end

        // R7 and R9: status mirror, chip select high during programming
        wr_addr = 10'h0AB; wr_data = 16'hBEEF; wr_start = 1'b1;
        step();
        wr_start = 1'b0;
        for (int j = 0; j < HOLD + 2; j++) step();
        csel = 1'b1; sck = 1'b1;
        step();
        csel = 1'b0;
        step();
        chk("R7", "fall with sck high ignored", 32'(do_stat_en), 32'd0);
        sck = 1'b0;
        step();
        chk("R7", "no late enable", 32'(do_stat_en), 32'd0);
        csel = 1'b1;
        step();
        csel = 1'b0;
        step();
        chk("R7", "status enabled", 32'(do_stat_en), 32'd1);
        chk("R7", "status shows busy", 32'(do_stat), 32'd0);
        csel = 1'b1;
        step();
        chk("R7", "status drops on deselect", 32'(do_stat_en), 32'd0);
        chk("R9", "cs high keeps busy", 32'(rdy), 32'd0);
        for (int j = 0; j < PROG && !rdy; j++) step();
        chk("R9", "commit with cs high", 32'(mem_we), 32'd1);
        chk("R9", "commit data", 32'(mem_wdata), 32'hBEEF);
        step();
        chk("R8", "cs high returns idle", 32'(iface_rst), 32'd1);
        csel = 1'b0;
        step();
        // status shows ready after completion
        wr_addr = 10'h0AC; wr_data = 16'h0001; wr_start = 1'b1;
        step();
        wr_start = 1'b0;
        csel = 1'b1;
        step();
        csel = 1'b0;
        step();
        chk("R7", "status enabled in delay", 32'(do_stat_en), 32'd1);
        for (int j = 0; j < HOLD + PROG && (!rdy || j < HOLD); j++) step();
        chk("R7", "status shows ready", 32'(do_stat), 32'd1);
        chk("R7", "status still enabled", 32'(do_stat_en), 32'd1);
        csel = 1'b1;
        step();
        chk("R7", "status off after deselect", 32'(do_stat_en), 32'd0);
        chk("R8", "idle pulse", 32'(iface_rst), 32'd1);
        csel = 1'b0;
        step();

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int m;
            int kk;
            m  = $urandom_range(0, 2);
            kk = (m == 1) ? $urandom_range(0, HOLD - 1) :
                 (m == 2) ? $urandom_range(0, PROG - 1) : 0;
            run_op(AW'($urandom), DW'($urandom), m, kk, 1'b1);
            csel = 1'b1;
            step();
            csel = 1'b0;
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule